// File: doc/BRIEF.md
# Zone-Based Access Permission Checker

This block rules on whether a memory access that has already been translated may go ahead. It takes the attribute byte of the matching translation entry, the current privilege mode, the kind of access and the entry's own execute and write permission bits. It returns a grant or a fault, a two-bit fault cause and the read/write rights the access is given. A per-zone override sits on top of the page permissions. Software loads a protection register that holds one two-bit code for each of sixteen zones. A four-bit field of the attribute byte picks which zone applies.

The zone code can pass the decision down to the page bits. It can also shut out user mode, or open everything to the supervisor or to both modes. The decision is purely combinational from the inputs and the stored register. The register is the only state. It loads in full on a write strobe at a clock edge.

Top module: `zone_access_check`

## Requirements
- R1: The zone index is attribute bits 7:4. The code for zone z sits in protection register bits [31-2z : 30-2z], so zone 0 uses bits 31:30 and zone 15 uses bits 1:0.
- R2: The protection register resets to all zeros. It loads all 32 bits from the write data on a clock edge where the write strobe is high, and it holds otherwise. A loaded value governs decisions from the cycle after that edge.
- R3: Code 3 grants every access in both modes, with read and write rights both set and cause 2'b00.
- R4: Code 0 in user mode (user_mode=1) denies every access with cause 2'b01 and no rights.
- R5: Code 0 in supervisor mode, and code 1 in either mode, defer to the page bits.
- R6: Code 2 grants everything with full rights in supervisor mode and defers to the page bits in user mode.
- R7: A deferred fetch (acc_type 2'b00) with the execute bit clear faults with cause 2'b10 and no rights. With the bit set it is granted, with read rights and write rights equal to the page write bit.
- R8: A deferred data access (acc_type 2'b01 read; 2'b10 or 2'b11 write) gets read rights, and write rights equal to the page write bit. A write to a page whose write bit is clear faults with cause 2'b11 and keeps read-only rights. Any other data access is granted.
- R9: grant is high exactly when the cause is 2'b00. A granted access always has read rights, and a granted write always has write rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| zpr_wr_en | input | 1 | Load strobe for the protection register |
| zpr_wr_data | input | 32 | New protection register contents |
| attr | input | 8 | Attribute byte of the hit entry |
| user_mode | input | 1 | 1 = user, 0 = supervisor |
| acc_type | input | 2 | 00 fetch, 01 read, 1x write |
| pg_exec | input | 1 | Entry execute permission |
| pg_write | input | 1 | Entry write permission |
| grant | output | 1 | Access allowed |
| fault_cause | output | 2 | 00 none, 01 zone, 10 execute, 11 write |
| rd_ok | output | 1 | Read right given |
| wr_ok | output | 1 | Write right given |

## Verification
The bench goes after the bit order of the register slice by placing a single full-grant code in one zone and sweeping all sixteen selects. A reversed or shifted slice would grant on the wrong zone. It checks code 2 in both modes, because a design that treats it like code 1 would fault supervisor accesses that should pass. It also checks code 0 in supervisor mode, where a design that denies regardless of mode would fault accesses the page bits allow. Random traffic with mid-stream register writes catches a write fault that drops the read rights, a fetch that wrongly checks the write bit, and a register that loads a cycle early or late.

// File: rtl/zone_access_pkg.sv
package zone_access_pkg;

   // two-bit per-zone override codes
   typedef enum logic [1:0] {
      ZC_DENY_USER  = 2'b00,
      ZC_PAGE       = 2'b01,
      ZC_SUPER_FULL = 2'b10,
      ZC_FULL       = 2'b11
   } zone_code_e;

   // fault cause codes
   typedef enum logic [1:0] {
      FC_NONE  = 2'b00,
      FC_ZONE  = 2'b01,
      FC_EXEC  = 2'b10,
      FC_WRITE = 2'b11
   } fault_e;

   // access kind: 00 fetch, 01 read, 1x write
   function automatic logic acc_is_fetch(input logic [1:0] acc);
      return acc == 2'b00;
   endfunction

   function automatic logic acc_is_write(input logic [1:0] acc);
      return acc[1];
   endfunction

   typedef struct packed {
      logic   grant;
      fault_e cause;
      logic   rd;
      logic   wr;
   } verdict_t;

endpackage

// File: rtl/zone_prot_reg.sv
module zone_prot_reg #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (wr_en_i) begin
         q_o <= wr_data_i;
      end
   end

endmodule

// File: rtl/zone_code_sel.sv
module zone_code_sel #(
   parameter int ZONE_CNT = 16,
   parameter int CODE_W   = 2,
   localparam int ZSEL_W  = $clog2(ZONE_CNT),
   localparam int REG_W   = ZONE_CNT * CODE_W
) (
   input  logic [REG_W-1:0]  zpr_i,
   input  logic [ZSEL_W-1:0] zsel_i,
   output logic [CODE_W-1:0] code_o
);

   logic [CODE_W-1:0] codes [ZONE_CNT];

   // zone 0 occupies the most significant slice
   for (genvar z = 0; z < ZONE_CNT; z++) begin : g_slice
      assign codes[z] = zpr_i[REG_W-1-z*CODE_W -: CODE_W];
   end

   assign code_o = codes[zsel_i];

endmodule

// File: rtl/zone_rule_eval.sv
module zone_rule_eval
   import zone_access_pkg::*;
(
   input  logic [1:0] code_i,
   input  logic       user_i,
   input  logic [1:0] acc_i,
   input  logic       pg_exec_i,
   input  logic       pg_write_i,
   output verdict_t   verdict_o
);

   logic   defer;
   logic   full;
   logic   zone_deny;
   fault_e cause;
   logic   rd;
   logic   wr;

   // zone level: full grant, deny, or hand off to the page
   always_comb begin
      defer     = 1'b0;
      full      = 1'b0;
      zone_deny = 1'b0;
      case (zone_code_e'(code_i))
         ZC_FULL:       full = 1'b1;
         ZC_SUPER_FULL: begin
            if (user_i) defer = 1'b1;
            else        full  = 1'b1;
         end
         ZC_PAGE:       defer = 1'b1;
         default: begin
            if (user_i) zone_deny = 1'b1;
            else        defer     = 1'b1;
         end
      endcase
   end

   // page level
   always_comb begin
      cause = FC_NONE;
      rd    = 1'b0;
      wr    = 1'b0;
      if (full) begin
         rd = 1'b1;
         wr = 1'b1;
      end else if (zone_deny) begin
         cause = FC_ZONE;
      end else if (defer) begin
         if (acc_is_fetch(acc_i)) begin
            if (!pg_exec_i) begin
               cause = FC_EXEC;
            end else begin
               rd = 1'b1;
               wr = pg_write_i;
            end
         end else begin
            rd = 1'b1;
            wr = pg_write_i;
            if (acc_is_write(acc_i) && !pg_write_i) cause = FC_WRITE;
         end
      end
   end

   assign verdict_o.grant = (cause == FC_NONE);
   assign verdict_o.cause = cause;
   assign verdict_o.rd    = rd;
   assign verdict_o.wr    = wr;

endmodule

// File: rtl/zone_access_check.sv
module zone_access_check
   import zone_access_pkg::*;
#(
   parameter int ZONE_CNT = 16,
   parameter int CODE_W   = 2,
   parameter int ATTR_W   = 8,
   parameter int ZSEL_LSB = 4,
   localparam int ZSEL_W  = $clog2(ZONE_CNT),
   localparam int REG_W   = ZONE_CNT * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zpr_wr_en,
   input  logic [REG_W-1:0]  zpr_wr_data,
   input  logic [ATTR_W-1:0] attr,
   input  logic              user_mode,
   input  logic [1:0]        acc_type,
   input  logic              pg_exec,
   input  logic              pg_write,
   output logic              grant,
   output logic [1:0]        fault_cause,
   output logic              rd_ok,
   output logic              wr_ok
);

   // elaboration checks
   if (CODE_W != 2) begin : g_bad_code_w
      $error("zone_access_check: CODE_W must be 2");
   end
   if ((1 << ZSEL_W) != ZONE_CNT) begin : g_bad_zone_cnt
      $error("zone_access_check: ZONE_CNT must be a power of two");
   end
   if (ZSEL_LSB + ZSEL_W > ATTR_W) begin : g_bad_attr
      $error("zone_access_check: zone field exceeds attribute width");
   end

   logic [REG_W-1:0]  zpr_q;
   logic [ZSEL_W-1:0] zsel;
   logic [CODE_W-1:0] zcode;
   verdict_t          verdict;

   assign zsel = attr[ZSEL_LSB +: ZSEL_W];

   // attribute bits outside the zone field carry nothing for this block
   if (ZSEL_LSB > 0) begin : g_low_sink
      logic unused_attr_low;
      assign unused_attr_low = ^attr[ZSEL_LSB-1:0];
   end
   if (ATTR_W > ZSEL_LSB + ZSEL_W) begin : g_high_sink
      logic unused_attr_high;
      assign unused_attr_high = ^attr[ATTR_W-1:ZSEL_LSB+ZSEL_W];
   end

   zone_prot_reg #(.REG_W(REG_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (zpr_wr_en),
      .wr_data_i (zpr_wr_data),
      .q_o       (zpr_q)
   );

   zone_code_sel #(.ZONE_CNT(ZONE_CNT), .CODE_W(CODE_W)) u_sel (
      .zpr_i  (zpr_q),
      .zsel_i (zsel),
      .code_o (zcode)
   );

   zone_rule_eval u_eval (
      .code_i     (zcode),
      .user_i     (user_mode),
      .acc_i      (acc_type),
      .pg_exec_i  (pg_exec),
      .pg_write_i (pg_write),
      .verdict_o  (verdict)
   );

   assign grant       = verdict.grant;
   assign fault_cause = verdict.cause;
   assign rd_ok       = verdict.rd;
   assign wr_ok       = verdict.wr;

endmodule

// File: rtl/zone_access_check_chk.sv
module zone_access_check_chk #(
   parameter int ZONE_CNT = 16,
   parameter int CODE_W   = 2,
   localparam int REG_W   = ZONE_CNT * CODE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             zpr_wr_en,
   input logic [REG_W-1:0] zpr_wr_data,
   input logic [REG_W-1:0] zpr_q,
   input logic             user_mode,
   input logic [1:0]       acc_type,
   input logic             pg_exec,
   input logic             pg_write,
   input logic             grant,
   input logic [1:0]       fault_cause,
   input logic             rd_ok,
   input logic             wr_ok
);

   p_reg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      zpr_wr_en |=> zpr_q == $past(zpr_wr_data));

   p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !zpr_wr_en |=> $stable(zpr_q));

   p_zone_deny_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cause == 2'b01 |-> user_mode && !rd_ok && !wr_ok);

   p_super_no_zone_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !user_mode |-> fault_cause != 2'b01);

   p_exec_fault_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cause == 2'b10 |-> acc_type == 2'b00 && !pg_exec && !rd_ok && !wr_ok);

   p_write_fault_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_cause == 2'b11 |-> acc_type[1] && !pg_write && rd_ok && !wr_ok);

   p_grant_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> rd_ok);

   p_grant_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant && acc_type[1] |-> wr_ok);

endmodule

bind zone_access_check zone_access_check_chk #(
   .ZONE_CNT (ZONE_CNT),
   .CODE_W   (CODE_W)
) u_chk (.*);

// File: tb/zone_access_check_bench.sv
`timescale 1ns/1ps
module zone_access_check_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        zpr_wr_en = 1'b0;
   logic [31:0] zpr_wr_data = '0;
   logic [7:0]  attr = '0;
   logic        user_mode = 1'b1;
   logic [1:0]  acc_type = 2'b01;
   logic        pg_exec = 1'b0;
   logic        pg_write = 1'b0;
   logic        grant;
   logic [1:0]  fault_cause;
   logic        rd_ok;
   logic        wr_ok;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    started = 0;
   bit    done = 0;
   string phase_tag = "";
   logic [31:0] m_zpr;

   always #2 clk = ~clk;

   zone_access_check u_zone_access_check (
      .clk(clk), .rst_n(rst_n), .zpr_wr_en(zpr_wr_en), .zpr_wr_data(zpr_wr_data),
      .attr(attr), .user_mode(user_mode), .acc_type(acc_type), .pg_exec(pg_exec),
      .pg_write(pg_write), .grant(grant), .fault_cause(fault_cause),
      .rd_ok(rd_ok), .wr_ok(wr_ok)
   );

   // reference register (R2)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)         m_zpr <= 32'd0;
      else if (zpr_wr_en) m_zpr <= zpr_wr_data;
   end

   // behavioural rule model; exp = {grant, cause[1:0], rd, wr}
   function automatic void model(output logic [4:0] exp, output string tag);
      int z;
      int code;
      bit defer;
      z    = int'(attr[7:4]);
      code = int'((m_zpr >> (30 - 2 * z)) & 32'd3);
      defer = 0;
      exp  = 5'b0_00_00;
      tag  = "R5";
      if (code == 3) begin
         exp = 5'b1_00_11; tag = "R3";
      end else if (code == 2 && !user_mode) begin
         exp = 5'b1_00_11; tag = "R6";
      end else if (code == 0 && user_mode) begin
         exp = 5'b0_01_00; tag = "R4";
      end else begin
         defer = 1;
         if (code == 2) tag = "R6";
      end
      if (defer) begin
         if (acc_type == 2'b00) begin
            tag = "R7";
            if (!pg_exec) exp = 5'b0_10_00;
            else          exp = {1'b1, 2'b00, 1'b1, pg_write};
         end else begin
            tag = "R8";
            if (acc_type[1] && !pg_write) exp = 5'b0_11_10;
            else                          exp = {1'b1, 2'b00, 1'b1, pg_write};
         end
      end
   endfunction

   // compare away from the active edge (R9 covered by every grant/cause pair)
   always @(negedge clk) begin
      logic [4:0] exp;
      logic [4:0] act;
      string      tag;
      if (started && !done) begin
         model(exp, tag);
         if (phase_tag != "") tag = phase_tag;
         act = {grant, fault_cause, rd_ok, wr_ok};
         n_cmp++;
         if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: zone=%0d user=%0b acc=%0b x=%0b w=%0b got %b expected %b",
                     tag, attr[7:4], user_mode, acc_type, pg_exec, pg_write, act, exp);
         end
         if (act[4] !== (act[3:2] == 2'b00)) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9: grant %b with cause %b expected grant %b",
                     act[4], act[3:2], act[3:2] == 2'b00);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic write_zpr(input logic [31:0] v);
      zpr_wr_en   = 1'b1;
      zpr_wr_data = v;
      step();
      zpr_wr_en   = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R2: reset state, all zones code 0, user read denied
      phase_tag = "R2";
      attr = 8'h00; user_mode = 1'b1; acc_type = 2'b01;
      @(posedge clk);
      #1 started = 1;
      repeat (3) step();
      rst_n = 1'b1;
      repeat (2) step();
      attr = 8'hF0; step();

      // R1: one full-grant zone at a time, sweep every select
      phase_tag = "R1";
      for (int z = 0; z < 16; z++) begin
         write_zpr(32'd3 << (30 - 2 * z));
         user_mode = 1'b1; acc_type = 2'b10; pg_exec = 1'b0; pg_write = 1'b0;
         for (int s = 0; s < 16; s++) begin
            attr = {s[3:0], 4'hA};
            step();
         end
      end

      // R2: write strobe low must not load; value applies after the edge
      phase_tag = "R2";
      zpr_wr_data = 32'hFFFF_FFFF;
      attr = 8'h00; user_mode = 1'b1; acc_type = 2'b01;
      repeat (3) step();
      write_zpr(32'h5555_5555);
      step();
      write_zpr(32'hAAAA_AAAA);
      user_mode = 1'b0; step();
      user_mode = 1'b1; step();

      // R6 / R5: code 2 and code 0 in supervisor mode, every access kind
      phase_tag = "";
      write_zpr(32'h2222_2222);
      for (int m = 0; m < 32; m++) begin
         attr = {m[1] ? 4'h1 : 4'h0, 4'h0};
         user_mode = m[0];
         acc_type = m[3:2];
         pg_exec = m[4];
         pg_write = m[2];
         step();
      end

      // R3..R8: random traffic with occasional register loads
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 16) == 0) begin
            zpr_wr_en   = 1'b1;
            zpr_wr_data = $urandom;
         end else begin
            zpr_wr_en = 1'b0;
         end
         attr      = 8'($urandom);
         user_mode = 1'($urandom);
         acc_type  = 2'($urandom);
         pg_exec   = 1'($urandom);
         pg_write  = 1'($urandom);
         step();
      end
      zpr_wr_en = 1'b0;
      step();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule